// File: doc/BRIEF.md
# Arithmetic Logic Unit with Condition Flags

This block is a purely combinational arithmetic logic unit. It takes two operands of a parameterised width (four bits by default) and a four-bit operation select. From these it produces a result word and five condition flags. The operations are two's-complement addition and subtraction, eight bitwise functions, and four single-position shifts of the first operand.

A surrounding datapath places operands on the inputs and reads the result and flags in the same cycle. There are no registers inside the block. A caller that needs to keep the flags latches them itself.

Top module: `alu_flags`

## Requirements
- R1: Select 0 (add) gives result = (A + B) mod 2^W. `flag_c` is the unsigned carry out. `flag_v` is set when A and B have the same sign bit and the result sign differs from it. For A=1101, B=1010 this gives 0111 with carry set.
- R2: Select 1 (subtract) gives result = (A - B) mod 2^W, computed as A + ~B + 1. `flag_c` is 1 exactly when no borrow occurs (A >= B unsigned). `flag_v` is set when A and B differ in sign and the result sign differs from A.
- R3: Selects 2 to 7 give AND, OR, XOR, NAND, NOR and XNOR of A and B, in that order. For A=1101, B=1010 the results are 1000, 1111, 0111, 0111, 0000 and 1000. `flag_c` and `flag_v` are 0.
- R4: Select 8 gives ~A and select 9 gives ~B, with `flag_c` and `flag_v` at 0. For A=1101, B=1010 the results are 0010 and 0101.
- R5: Select 10 shifts A left by one and fills bit 0 with 0; `flag_c` takes the old MSB of A. Select 11 shifts A right by one and fills the MSB with 0; `flag_c` takes the old bit 0 of A. `flag_v` is 0 for both.
- R6: Select 12 shifts A right by one and keeps the old MSB in the new MSB (1101 gives 1110). `flag_c` takes the old bit 0 and `flag_v` is 0. B is ignored by every shift.
- R7: Select 13 rotates A right by one, so the old bit 0 becomes the MSB (1101 gives 1110). `flag_c` takes the old bit 0 and `flag_v` is 0.
- R8: `flag_z` is 1 exactly when the result is all zeros. `flag_n` equals the MSB of the result.
- R9: `flag_p` is 1 exactly when the result holds an even number of one bits.
- R10: Selects 14 and 15 are unused. They give a zero result with `flag_z` and `flag_p` set and `flag_c`, `flag_n` and `flag_v` clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | WIDTH | First operand; the only operand of shifts and rotate |
| b_in | input | WIDTH | Second operand |
| op_sel | input | 4 | Operation select |
| result | output | WIDTH | Operation result |
| flag_z | output | 1 | Result is all zeros |
| flag_c | output | 1 | Carry, no-borrow, or bit shifted out |
| flag_n | output | 1 | Result MSB |
| flag_v | output | 1 | Signed overflow |
| flag_p | output | 1 | Even parity of result |

## Verification
At the default width the bench sweeps every select against every operand pair, so each corner case is covered.

- Subtraction carry polarity: a design that raised carry on borrow would fail every pair with A below B.
- Overflow conditions: swapping the add and subtract sign tests would miss overflows such as 0111 + 0001 and 1000 - 0001.
- Shift fill and carry: an arithmetic shift that filled with zero, or a rotate that dropped bit 0, would break on any odd operand or any operand with its MSB set. Taking the carry from the wrong end would break the same way.
- Parity sense and unused selects: inverted parity, or flags left set on an unused select, would show up across the whole sweep.

// File: rtl/alu_flags.sv
module alu_flags #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic [3:0]       op_sel,
  output logic [WIDTH-1:0] result,
  output logic             flag_z,
  output logic             flag_c,
  output logic             flag_n,
  output logic             flag_v,
  output logic             flag_p
);
  localparam int MSB = WIDTH - 1;

  localparam logic [3:0] OP_ADD  = 4'd0;
  localparam logic [3:0] OP_SUB  = 4'd1;
  localparam logic [3:0] OP_AND  = 4'd2;
  localparam logic [3:0] OP_OR   = 4'd3;
  localparam logic [3:0] OP_XOR  = 4'd4;
  localparam logic [3:0] OP_NAND = 4'd5;
  localparam logic [3:0] OP_NOR  = 4'd6;
  localparam logic [3:0] OP_XNOR = 4'd7;
  localparam logic [3:0] OP_NOTA = 4'd8;
  localparam logic [3:0] OP_NOTB = 4'd9;
  localparam logic [3:0] OP_SHL  = 4'd10;
  localparam logic [3:0] OP_SHR  = 4'd11;
  localparam logic [3:0] OP_ASR  = 4'd12;
  localparam logic [3:0] OP_ROR  = 4'd13;

  logic [WIDTH:0] add_ext;
  logic [WIDTH:0] sub_ext;
  logic           add_ovf;
  logic           sub_ovf;
  logic           cy;
  logic           ov;

  assign add_ext = {1'b0, a_in} + {1'b0, b_in};
  assign sub_ext = {1'b0, a_in} + {1'b0, ~b_in} + {{WIDTH{1'b0}}, 1'b1};
  assign add_ovf = (a_in[MSB] == b_in[MSB]) && (add_ext[MSB] != a_in[MSB]);
  assign sub_ovf = (a_in[MSB] != b_in[MSB]) && (sub_ext[MSB] != a_in[MSB]);

  always_comb begin
    result = '0;
    cy     = 1'b0;
    ov     = 1'b0;
    case (op_sel)
      OP_ADD:  begin result = add_ext[MSB:0]; cy = add_ext[WIDTH]; ov = add_ovf; end
      OP_SUB:  begin result = sub_ext[MSB:0]; cy = sub_ext[WIDTH]; ov = sub_ovf; end
      OP_AND:  result = a_in & b_in;
      OP_OR:   result = a_in | b_in;
      OP_XOR:  result = a_in ^ b_in;
      OP_NAND: result = ~(a_in & b_in);
      OP_NOR:  result = ~(a_in | b_in);
      OP_XNOR: result = ~(a_in ^ b_in);
      OP_NOTA: result = ~a_in;
      OP_NOTB: result = ~b_in;
      OP_SHL:  begin result = {a_in[MSB-1:0], 1'b0};      cy = a_in[MSB]; end
      OP_SHR:  begin result = {1'b0, a_in[MSB:1]};        cy = a_in[0];   end
      OP_ASR:  begin result = {a_in[MSB], a_in[MSB:1]};   cy = a_in[0];   end
      OP_ROR:  begin result = {a_in[0], a_in[MSB:1]};     cy = a_in[0];   end
      default: result = '0;
    endcase
  end

  assign flag_c = cy;
  assign flag_v = ov;
  assign flag_z = (result == '0);
  assign flag_n = result[MSB];
  assign flag_p = ~^result;
endmodule

// File: rtl/alu_flags_chk.sv
module alu_flags_chk #(
  parameter int WIDTH = 4
) (
  input logic [WIDTH-1:0] a_in,
  input logic [WIDTH-1:0] b_in,
  input logic [3:0]       op_sel,
  input logic [WIDTH-1:0] result,
  input logic             flag_z,
  input logic             flag_c,
  input logic             flag_n,
  input logic             flag_v,
  input logic             flag_p
);
  logic [WIDTH:0] wide_sum;
  assign wide_sum = {1'b0, a_in} + {1'b0, b_in};

  always_comb begin
    if (op_sel == 4'd0)
      assert_add_carry_R1: assert ({flag_c, result} == wide_sum)
        else $error("R1 add result/carry mismatch");
    if (op_sel == 4'd1)
      assert_sub_noborrow_R2: assert (flag_c == (a_in >= b_in))
        else $error("R2 subtract carry polarity");
    if (op_sel >= 4'd2 && op_sel <= 4'd7)
      assert_logic_flags_R3: assert (!flag_c && !flag_v)
        else $error("R3 logic op left C or V set");
    if (op_sel == 4'd8)
      assert_not_a_R4: assert ((result ^ a_in) == {WIDTH{1'b1}})
        else $error("R4 NOT A wrong");
    if (op_sel >= 4'd10 && op_sel <= 4'd13)
      assert_shift_no_ovf_R5: assert (!flag_v)
        else $error("R5 shift set V");
    if (op_sel == 4'd13)
      assert_rotate_ones_R7: assert ($countones(result) == $countones(a_in))
        else $error("R7 rotate changed one count");
    assert_zero_flag_R8: assert (flag_z == ($countones(result) == 0))
      else $error("R8 zero flag mismatch");
    assert_parity_R9: assert (flag_p == ($countones(result) % 2 == 0))
      else $error("R9 parity mismatch");
    if (op_sel >= 4'd14)
      assert_unused_op_R10: assert (result == '0 && flag_z && flag_p && !flag_c && !flag_n && !flag_v)
        else $error("R10 unused select output");
  end
endmodule

bind alu_flags alu_flags_chk #(.WIDTH(WIDTH)) u_chk (
  .a_in(a_in), .b_in(b_in), .op_sel(op_sel), .result(result),
  .flag_z(flag_z), .flag_c(flag_c), .flag_n(flag_n), .flag_v(flag_v), .flag_p(flag_p)
);

// File: tb/tb_alu_flags.sv
`timescale 1ns/1ps
module tb_alu_flags;
  localparam int W = 4;
  localparam int M = 1 << W;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [W-1:0] a_in, b_in, result;
  logic [3:0]   op_sel;
  logic         flag_z, flag_c, flag_n, flag_v, flag_p;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  alu_flags #(.WIDTH(W)) dut (
    .a_in(a_in), .b_in(b_in), .op_sel(op_sel), .result(result),
    .flag_z(flag_z), .flag_c(flag_c), .flag_n(flag_n), .flag_v(flag_v), .flag_p(flag_p)
  );

  // packed as {result, z, c, n, v, p}
  function automatic logic [W+4:0] model(int a, int b, int op);
    int r, c, v, sa, sb, sv, ones;
    r = 0; c = 0; v = 0;
    sa = (a >= M/2) ? a - M : a;
    sb = (b >= M/2) ? b - M : b;
    case (op)
      0: begin r = (a + b) % M; c = (a + b >= M); sv = sa + sb; v = (sv >= M/2 || sv < -M/2); end
      1: begin r = (a + (M-1-b) + 1) % M; c = (a >= b); sv = sa - sb; v = (sv >= M/2 || sv < -M/2); end
      2: r = a & b;
      3: r = a | b;
      4: r = a ^ b;
      5: r = (M-1) - (a & b);
      6: r = (M-1) - (a | b);
      7: r = (M-1) - (a ^ b);
      8: r = (M-1) - a;
      9: r = (M-1) - b;
      10: begin r = (a * 2) % M; c = a / (M/2); end
      11: begin r = a / 2; c = a % 2; end
      12: begin r = a / 2 + ((a >= M/2) ? M/2 : 0); c = a % 2; end
      13: begin r = a / 2 + (a % 2) * (M/2); c = a % 2; end
      default: r = 0;
    endcase
    ones = 0;
    for (int i = 0; i < W; i++) ones += (r >> i) & 1;
    return {r[W-1:0], (r == 0), c[0], (r >= M/2), v[0], ((ones % 2) == 0)};
  endfunction

  function automatic string req_of(int op);
    case (op)
      0: return "R1";
      1: return "R2";
      2, 3, 4, 5, 6, 7: return "R3";
      8, 9: return "R4";
      10, 11: return "R5";
      12: return "R6";
      13: return "R7";
      default: return "R10";
    endcase
  endfunction

  task automatic apply(int a, int b, int op);
    @(posedge clk);
    a_in = a[W-1:0]; b_in = b[W-1:0]; op_sel = op[3:0];
    @(negedge clk);
  endtask

  task automatic check(string req, logic [W+4:0] exp);
    logic [W+4:0] got;
    got = {result, flag_z, flag_c, flag_n, flag_v, flag_p};
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s op=%0d a=%b b=%b got={res,z,c,n,v,p}=%b exp=%b",
               req, op_sel, a_in, b_in, got, exp);
    end
  endtask

  initial begin
    a_in = '0; b_in = '0; op_sel = '0;
    // zero inputs: add of 0+0, R8 and R9 (Z=1, P=1)
    apply(0, 0, 0);  check("R8", {4'b0000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1});
    // documented vectors, A=1101 B=1010
    apply(13, 10, 0);  check("R1", {4'b0111, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0});
    apply(13, 10, 2);  check("R3", {4'b1000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0});
    apply(13, 10, 3);  check("R3", {4'b1111, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1});
    apply(13, 10, 6);  check("R3", {4'b0000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1});
    apply(13, 10, 8);  check("R4", {4'b0010, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0});
    apply(13, 10, 9);  check("R4", {4'b0101, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1});
    apply(13, 10, 12); check("R6", {4'b1110, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0});
    apply(13, 10, 13); check("R7", {4'b1110, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0});
    // overflow corners R1, R2
    apply(7, 1, 0);  check("R1", {4'b1000, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0});
    apply(8, 1, 1);  check("R2", {4'b0111, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0});
    apply(3, 5, 1);  check("R2", {4'b1110, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0});
    apply(9, 0, 10); check("R5", {4'b0010, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0});
    apply(9, 0, 11); check("R5", {4'b0100, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0});
    apply(15, 15, 14); check("R10", {4'b0000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1});
    // exhaustive sweep: every select, every operand pair (covers R8, R9 on all results)
    for (int op = 0; op < 16; op++)
      for (int a = 0; a < M; a++)
        for (int b = 0; b < M; b++) begin
          apply(a, b, op);
          check(req_of(op), model(a, b, op));
        end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, got=hung exp=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule